// File: doc/BRIEF.md
# Index-Distance Reference Capture Unit

This unit sits next to a position counter that is fed with step pulses and a direction bit from a quadrature decoder. It measures the signed number of counting edges between two index marks. When the measurement completes, it latches that distance into a readable reference register and tells the main position counter to clear. The main position is then referenced to the second mark.

An internal 24-bit two's-complement edge counter is zeroed by every index pulse and moves with every step. The counter itself is not visible. The capture sequence is armed out of reset and again by a zero-codification command. Once armed, the first index starts the measurement. The next index that is not the same mark completes it: the reference register loads the count, a one-cycle clear pulse goes to the main counter, and a sticky valid flag is raised. A main-counter reset request or a new zero-codification command drops the valid flag.

The reference value, the valid flag and the clear pulse are plain registered status signals. They are not a stream, so the unit has no handshake and never applies back-pressure. All three outputs change on the clock edge that samples the completing index.

Top module: `refcap_unit`

## Requirements
- R1: A step pulse with `step_dir` high adds one to the internal count, and with `step_dir` low subtracts one. The count is 24-bit two's complement and wraps modulo 2^24, so one step down from zero reads 0xFFFFFF once captured. With no step and no index, the count holds.
- R2: Every index pulse zeroes the internal count in every sequence state. An index wins over a step in the same cycle.
- R3: After reset the sequence is armed. The first index only starts the measurement: `ref_value`, `ref_valid` and `main_clr` stay unchanged.
- R4: In the measuring state, an index that arrives with a nonzero count loads `ref_value` with that count, as a 24-bit two's-complement value. The load shows on the edge that samples the index.
- R5: In the measuring state, an index that arrives while the count is still zero is treated as the same mark. It does not complete the capture.
- R6: A capture drives `main_clr` high for exactly one cycle, registered on the edge that samples the completing index.
- R7: `ref_valid` rises on a capture and stays high until a reset, a `zero_cmd` or a `main_rst_req`. Either request clears it on the next edge.
- R8: `zero_cmd` re-arms the sequence, so a new first index is needed before any capture. It leaves `ref_value` unchanged. When it coincides with an index, the index acts as a first index only.
- R9: After a capture, further index pulses zero the count but neither reload `ref_value` nor pulse `main_clr`.
- R10: During and right after reset, `ref_value` is 0, `ref_valid` is 0 and `main_clr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; arms the sequence |
| step_en | input | 1 | One counting edge this cycle |
| step_dir | input | 1 | Step direction, 1 = up, 0 = down |
| index_pulse | input | 1 | Single-cycle index mark |
| zero_cmd | input | 1 | Zero-codification command: re-arm and clear valid |
| main_rst_req | input | 1 | Main-counter reset request: clears valid |
| ref_value | output | 24 | Captured signed edge distance |
| ref_valid | output | 1 | Sticky capture-complete flag |
| main_clr | output | 1 | One-cycle clear request to the main position counter |

## Verification
The hardest situation to reach from the ports is a repeated index while the hidden count is still zero in the measuring state. It looks exactly like a real second mark, except that no step has occurred. The stimulus produces it by sending two back-to-back index pulses right after arming, and then a step and an index in the same cycle. A 2^23-step run to the signed limit would not fit in the cycle budget, so wrap-around is exercised through zero instead: a net negative distance must be captured as its 24-bit two's-complement code.

// File: rtl/refcap_pkg.sv
package refcap_pkg;
  localparam int unsigned REF_W = 24;

  typedef enum logic [1:0] {
    SEQ_WAIT_FIRST  = 2'd0,
    SEQ_WAIT_SECOND = 2'd1,
    SEQ_DONE        = 2'd2
  } seq_state_t;
endpackage

// File: rtl/refcap_counter.sv
module refcap_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         step_dir,
  input  logic         index_pulse,
  output logic [W-1:0] count,
  output logic         count_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)           count <= '0;
    else if (index_pulse) count <= '0;
    else if (step_en)     count <= step_dir ? count + ONE : count - ONE;
  end

  assign count_zero = (count == '0);

  assert_index_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    index_pulse |=> (count == '0));

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!index_pulse && !step_en) |=> $stable(count));
endmodule

// File: rtl/refcap_seq.sv
module refcap_seq
  import refcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       index_pulse,
  input  logic       zero_cmd,
  input  logic       count_zero,
  output logic       capture,
  output seq_state_t state
);
  seq_state_t state_nx;

  always_comb begin
    capture  = (state == SEQ_WAIT_SECOND) && index_pulse && !count_zero && !zero_cmd;
    state_nx = state;
    if (zero_cmd) begin
      state_nx = index_pulse ? SEQ_WAIT_SECOND : SEQ_WAIT_FIRST;
    end else begin
      case (state)
        SEQ_WAIT_FIRST:  if (index_pulse) state_nx = SEQ_WAIT_SECOND;
        SEQ_WAIT_SECOND: if (capture)     state_nx = SEQ_DONE;
        default:         state_nx = SEQ_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_WAIT_FIRST;
    else        state <= state_nx;
  end

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DONE && !zero_cmd) |=> (state == SEQ_DONE));

  assert_first_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT_FIRST) |-> !capture);

  assert_same_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT_SECOND && count_zero) |-> !capture);
endmodule

// File: rtl/refcap_hold.sv
module refcap_hold #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] count,
  input  logic         zero_cmd,
  input  logic         main_rst_req,
  output logic [W-1:0] ref_value,
  output logic         ref_valid,
  output logic         main_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_value <= '0;
      ref_valid <= 1'b0;
      main_clr  <= 1'b0;
    end else begin
      main_clr <= capture;
      if (capture) begin
        ref_value <= count;
        ref_valid <= 1'b1;
      end else if (zero_cmd || main_rst_req) begin
        ref_valid <= 1'b0;
      end
    end
  end

  assert_ref_only_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ref_value));

  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    main_clr |=> !main_clr);

  assert_valid_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_valid) |-> $past(zero_cmd || main_rst_req));
endmodule

// File: rtl/refcap_unit.sv
module refcap_unit
  import refcap_pkg::*;
#(
  parameter int unsigned W = REF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         step_dir,
  input  logic         index_pulse,
  input  logic         zero_cmd,
  input  logic         main_rst_req,
  output logic [W-1:0] ref_value,
  output logic         ref_valid,
  output logic         main_clr
);
  logic [W-1:0] count;
  logic         count_zero;
  logic         capture;
  seq_state_t   state;

  refcap_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_dir(step_dir),
    .index_pulse(index_pulse), .count(count), .count_zero(count_zero)
  );

  refcap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .index_pulse(index_pulse), .zero_cmd(zero_cmd),
    .count_zero(count_zero), .capture(capture), .state(state)
  );

  refcap_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture), .count(count),
    .zero_cmd(zero_cmd), .main_rst_req(main_rst_req),
    .ref_value(ref_value), .ref_valid(ref_valid), .main_clr(main_clr)
  );

  assert_valid_rise_on_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> $past(index_pulse));

  assert_clr_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    main_clr |-> ref_valid);
endmodule

// File: tb/sim_refcap_unit.sv
module sim_refcap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0, step_dir = 1'b0, index_pulse = 1'b0;
  logic        zero_cmd = 1'b0, main_rst_req = 1'b0;
  logic [23:0] ref_value;
  logic        ref_valid, main_clr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [23:0] ref_v;
    logic        valid;
    logic        clr;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [23:0] m_cnt = '0;
  logic [23:0] m_ref = '0;
  logic        m_valid = 1'b0;
  int          m_st = 0;
  string       tag = "R10";

  always #2.5 clk = ~clk;

  refcap_unit u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_dir(step_dir),
    .index_pulse(index_pulse), .zero_cmd(zero_cmd), .main_rst_req(main_rst_req),
    .ref_value(ref_value), .ref_valid(ref_valid), .main_clr(main_clr)
  );

  task automatic tick(input logic se, input logic sd, input logic ix,
                      input logic zc, input logic mr);
    exp_t e;
    logic cap;
    @(negedge clk);
    step_en = se; step_dir = sd; index_pulse = ix; zero_cmd = zc; main_rst_req = mr;
    cap = (m_st == 1) && ix && (m_cnt != 24'd0) && !zc;
    if (cap) m_ref = m_cnt;
    m_valid = cap ? 1'b1 : ((zc || mr) ? 1'b0 : m_valid);
    if (zc)                    m_st = ix ? 1 : 0;
    else if (m_st == 0 && ix)  m_st = 1;
    else if (cap)              m_st = 2;
    if (ix)      m_cnt = '0;
    else if (se) m_cnt = sd ? m_cnt + 24'd1 : m_cnt - 24'd1;
    e.ref_v = m_ref; e.valid = m_valid; e.clr = cap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic steps(input int n, input logic dir);
    for (int i = 0; i < n; i++) tick(1'b1, dir, 1'b0, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (ref_value !== e.ref_v || ref_valid !== e.valid || main_clr !== e.clr) begin
        errors++;
        $display("FAIL %s: ref=%h valid=%b clr=%b expected ref=%h valid=%b clr=%b",
                 e.tag, ref_value, ref_valid, main_clr, e.ref_v, e.valid, e.clr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R10 reset state
    if (ref_value !== 24'd0 || ref_valid !== 1'b0 || main_clr !== 1'b0) begin
      errors++;
      $display("FAIL R10: ref=%h valid=%b clr=%b expected 0 0 0", ref_value, ref_valid, main_clr);
    end
    @(negedge clk); rst_n = 1'b1;
    tag = "R10"; tick(0, 0, 0, 0, 0);
    tag = "R3";  steps(5, 1'b1); tick(0, 0, 1, 0, 0);
    tag = "R5";  tick(0, 0, 1, 0, 0); tick(0, 0, 1, 0, 0);
    tag = "R1";  steps(7, 1'b1); steps(2, 1'b0); tick(0, 0, 0, 0, 0);
    tag = "R4";  tick(0, 0, 1, 0, 0);
    tag = "R6";  tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
    tag = "R9";  steps(3, 1'b1); tick(0, 0, 1, 0, 0); tick(0, 0, 0, 0, 0);
    tag = "R7";  tick(0, 0, 0, 0, 1); tick(0, 0, 0, 0, 0);
    tag = "R8";  tick(0, 0, 0, 1, 0); steps(4, 1'b1); tick(0, 0, 1, 0, 0);
    tag = "R1";  steps(4, 1'b0);
    tag = "R4";  tick(0, 0, 1, 0, 0); tick(0, 0, 0, 0, 0);
    tag = "R7";  steps(2, 1'b1); tick(0, 0, 0, 0, 0);
    tag = "R2";  tick(1, 1, 1, 0, 0); tick(0, 0, 0, 0, 0);
    tag = "R8";  tick(0, 0, 1, 1, 0); steps(6, 1'b0); tick(1, 0, 1, 0, 0);
    tag = "R2";  tick(1, 1, 1, 0, 0); tick(0, 0, 1, 0, 0);
    tag = "R5";  steps(1, 1'b0); tick(0, 0, 1, 0, 0);
    tag = "R6";  tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
    tag = "R7";  tick(0, 0, 0, 1, 0); tick(0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule